// File: doc/BRIEF.md
# I2C Register-Access Slave Front End

This block is the serial front end of a small register file of up to seventeen byte locations. It watches the open-drain clock and data lines of a two-wire bus with a fast system clock. Both lines go through a synchronizer and a spike filter. The block then finds START, repeated START and STOP conditions and steps through the byte and acknowledge phases of each transfer. The data line is never driven high: the block only asserts a pull-low enable.

A transfer begins with an identification byte. Its upper four bits are a fixed prefix, the next three bits come from strap pins, and its last bit selects read or write. A write transfer carries a register address and one data byte. The block hands both to the back end with a one-cycle strobe. A read transfer first sets the address with a write-style header, then issues a repeated START and a read identification byte. The block then streams bytes from an internal pointer until the master declines one. The register contents stay in the back end: it presents the byte for the current pointer on `reg_rdata_i`, and the block pulses `stop_pulse_o` on each STOP.

Top module: `i2c_regport_slave`

## Requirements
- R1: An identification byte whose bits 7..4 are 1010 and whose bits 3..1 equal `strap_i[2:0]` is acknowledged by pulling SDA low during the ninth clock. Bit 0 selects the direction: 0 is write and 1 is read.
- R2: An identification byte that does not match is not acknowledged, and no later byte is acknowledged before the next START.
- R3: In a write, the address byte and the data byte are each acknowledged. The data byte then produces exactly one single-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the address byte and `reg_wdata_o` equal to the data byte.
- R4: A write carries one data byte only. Further bytes before STOP are not acknowledged and produce no write strobe.
- R5: After a repeated START and a read identification byte, the block sends the byte at the address given in the header, MSB first. Each byte that the master acknowledges is followed by the byte at the next address.
- R6: During a read, the pointer goes from address WRAP_AT (default 0Fh) back to 00h. Every other address increments by one.
- R7: After the master declines a read byte, the block releases SDA and acknowledges nothing until the next START.
- R8: Every STOP condition on the bus produces a `stop_pulse_o` pulse exactly one clock wide.
- R9: While `pwr_busy_i` is high, START conditions are ignored, so an identification byte that follows is not acknowledged.
- R10: Pulses on SCL or SDA shorter than the spike window (SPIKE_NS at SYS_CLK_MHZ) have no effect on a transfer.
- R11: `sda_drive_low_o` is raised only while the filtered SCL is low.
- R12: During and right after reset, SDA is released and neither `reg_we_o` nor `stop_pulse_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low |
| strap_i | input | 3 | Strap pins forming bits 3..1 of the identification byte |
| pwr_busy_i | input | 1 | While high, START conditions are ignored |
| reg_addr_o | output | 8 | Register pointer to the back end |
| reg_wdata_o | output | 8 | Write data to the back end |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Back-end byte at `reg_addr_o` |
| stop_pulse_o | output | 1 | One-cycle pulse on each STOP |

## Verification
The bench builds the block with SYS_CLK_MHZ=250, SPIKE_NS=50 and WRAP_AT=0Fh. These values give a 13-cycle spike window, so an 8-cycle spike on either line lands well inside the suppressed range while a 40-cycle bus phase passes cleanly. The default wrap point lets a four-byte burst from 0Eh cross from 0Fh to 00h. The 17-entry model of the back end covers the full address range, including location 10h past the wrap point.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam logic [3:0] ID_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_HALT
    } xfer_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic id_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == ID_PREFIX) && (b[3:1] == strap);
    endfunction

    function automatic logic [7:0] next_ptr(input logic [7:0] p, input logic [7:0] wrap_at);
        return (p == wrap_at) ? 8'h00 : p + 8'h01;
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int FILT_LEN = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic s1_q, s2_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            dout  <= 1'b1;
            cnt_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            if (s2_q == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                dout  <= s2_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_regport_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.scl_rise = scl_f & ~scl_q;
        evt.scl_fall = ~scl_f & scl_q;
        evt.start    = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
    import i2c_regport_pkg::*;
#(
    parameter logic [7:0] WRAP_AT = 8'h0F
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_evt_t    evt,
    input  logic        sda_f,
    input  logic [2:0]  strap_i,
    input  logic        pwr_busy_i,
    input  logic [7:0]  rdata_i,
    output logic        drive_low_o,
    output logic [7:0]  ptr_o,
    output logic [7:0]  wdata_o,
    output logic        we_o,
    output logic        stop_pulse_o,
    output xfer_state_e state_o,
    output logic        ptr_inc_o
);
    xfer_state_e state_q, next_q;
    logic [3:0]  bit_q;
    logic [7:0]  sh_q;
    logic        mack_q;
    logic        receiving;

    assign receiving = (state_q == ST_ID) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
    assign ptr_inc_o = (state_q == ST_RDATA) && evt.scl_fall && (bit_q == 4'd8);
    assign state_o   = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            next_q       <= ST_IDLE;
            bit_q        <= 4'd0;
            sh_q         <= 8'h00;
            mack_q       <= 1'b0;
            drive_low_o  <= 1'b0;
            ptr_o        <= 8'h00;
            wdata_o      <= 8'h00;
            we_o         <= 1'b0;
            stop_pulse_o <= 1'b0;
        end else begin
            we_o         <= 1'b0;
            stop_pulse_o <= 1'b0;
            if (evt.stop) begin
                state_q      <= ST_IDLE;
                drive_low_o  <= 1'b0;
                bit_q        <= 4'd0;
                stop_pulse_o <= 1'b1;
            end else if (evt.start && !pwr_busy_i) begin
                state_q     <= ST_ID;
                drive_low_o <= 1'b0;
                bit_q       <= 4'd0;
            end else if (receiving) begin
                if (evt.scl_rise) begin
                    if (bit_q < 4'd8) sh_q <= {sh_q[6:0], sda_f};
                    bit_q <= bit_q + 4'd1;
                end else if (evt.scl_fall) begin
                    if (bit_q == 4'd8) begin
                        case (state_q)
                            ST_ID: begin
                                if (id_match(sh_q, strap_i)) begin
                                    drive_low_o <= 1'b1;
                                    next_q      <= sh_q[0] ? ST_RDATA : ST_ADDR;
                                end else begin
                                    state_q <= ST_HALT;
                                end
                            end
                            ST_ADDR: begin
                                drive_low_o <= 1'b1;
                                ptr_o       <= sh_q;
                                next_q      <= ST_WDATA;
                            end
                            default: begin
                                drive_low_o <= 1'b1;
                                wdata_o     <= sh_q;
                                we_o        <= 1'b1;
                                next_q      <= ST_HALT;
                            end
                        endcase
                    end else if (bit_q == 4'd9) begin
                        bit_q   <= 4'd0;
                        state_q <= next_q;
                        if (next_q == ST_RDATA) begin
                            sh_q        <= rdata_i;
                            drive_low_o <= ~rdata_i[7];
                        end else begin
                            drive_low_o <= 1'b0;
                        end
                    end
                end
            end else if (state_q == ST_RDATA) begin
                if (evt.scl_rise) begin
                    if (bit_q == 4'd8) mack_q <= ~sda_f;
                    bit_q <= bit_q + 4'd1;
                end else if (evt.scl_fall) begin
                    if (bit_q == 4'd9) begin
                        if (mack_q) begin
                            bit_q       <= 4'd0;
                            sh_q        <= rdata_i;
                            drive_low_o <= ~rdata_i[7];
                        end else begin
                            state_q     <= ST_HALT;
                            drive_low_o <= 1'b0;
                        end
                    end else if (bit_q == 4'd8) begin
                        drive_low_o <= 1'b0;
                        ptr_o       <= next_ptr(ptr_o, WRAP_AT);
                    end else if (bit_q != 4'd0) begin
                        sh_q        <= {sh_q[6:0], 1'b0};
                        drive_low_o <= ~sh_q[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
    import i2c_regport_pkg::*;
#(
    parameter int         SYS_CLK_MHZ = 250,
    parameter int         SPIKE_NS    = 50,
    parameter logic [7:0] WRAP_AT     = 8'h0F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low_o,
    input  logic [2:0] strap_i,
    input  logic       pwr_busy_i,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_we_o,
    input  logic [7:0] reg_rdata_i,
    output logic       stop_pulse_o
);
    localparam int RAW_LEN  = (SYS_CLK_MHZ * SPIKE_NS + 999) / 1000;
    localparam int FILT_LEN = (RAW_LEN < 1) ? 1 : RAW_LEN;
    localparam int N_LINES  = 2;

    logic [N_LINES-1:0] line_raw, line_filt;
    logic               scl_filt, sda_filt;
    bus_evt_t           evt;
    xfer_state_e        xfer_state;
    logic               ptr_inc;

    assign line_raw = {sda_i, scl_i};
    assign scl_filt = line_filt[0];
    assign sda_filt = line_filt[1];

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[g]),
            .dout (line_filt[g])
        );
    end

    i2c_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_filt),
        .sda_f (sda_filt),
        .evt   (evt)
    );

    i2c_xfer_ctrl #(.WRAP_AT(WRAP_AT)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .sda_f        (sda_filt),
        .strap_i      (strap_i),
        .pwr_busy_i   (pwr_busy_i),
        .rdata_i      (reg_rdata_i),
        .drive_low_o  (sda_drive_low_o),
        .ptr_o        (reg_addr_o),
        .wdata_o      (reg_wdata_o),
        .we_o         (reg_we_o),
        .stop_pulse_o (stop_pulse_o),
        .state_o      (xfer_state),
        .ptr_inc_o    (ptr_inc)
    );
endmodule

// File: rtl/i2c_regport_checker.sv
module i2c_regport_checker
    import i2c_regport_pkg::*;
#(
    parameter logic [7:0] WRAP_AT = 8'h0F
) (
    input logic        clk,
    input logic        rst,
    input logic        scl_f,
    input logic        sda_drive_low_o,
    input logic        reg_we_o,
    input logic        stop_pulse_o,
    input logic        pwr_busy_i,
    input xfer_state_e state,
    input logic [7:0]  ptr,
    input logic        ptr_inc
);
    p_drive_on_low_scl_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low_o) |-> !$past(scl_f));

    p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> !reg_we_o);

    p_we_at_fall_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |-> !$past(scl_f));

    p_stop_single_r8: assert property (@(posedge clk) disable iff (rst)
        stop_pulse_o |=> !stop_pulse_o);

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(ptr_inc) && ($past(ptr) == WRAP_AT)) |-> (ptr == 8'h00));

    p_busy_stays_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_busy_i && state == ST_IDLE) |=> (state == ST_IDLE));

    p_halt_released_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> !sda_drive_low_o);
endmodule

bind i2c_regport_slave i2c_regport_checker #(.WRAP_AT(WRAP_AT)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .scl_f           (scl_filt),
    .sda_drive_low_o (sda_drive_low_o),
    .reg_we_o        (reg_we_o),
    .stop_pulse_o    (stop_pulse_o),
    .pwr_busy_i      (pwr_busy_i),
    .state           (xfer_state),
    .ptr             (reg_addr_o),
    .ptr_inc         (ptr_inc)
);

// File: tb/i2c_regport_slave_bench.sv
module i2c_regport_slave_bench;
    localparam int Q = 40;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pwr_busy = 1'b0;
    logic sda_drive_low, reg_we, stop_pulse;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;
    logic [7:0] mem [0:16];
    logic [15:0] exp_q [$];
    int n_chk = 0, n_fail = 0, stop_cnt = 0, exp_stops = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_line  = m_sda & ~sda_drive_low;
    assign reg_rdata = (reg_addr < 8'd17) ? mem[reg_addr[4:0]] : 8'h00;

    i2c_regport_slave u_i2c_regport_slave (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_drive_low_o(sda_drive_low), .strap_i(STRAP), .pwr_busy_i(pwr_busy),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
        .reg_rdata_i(reg_rdata), .stop_pulse_o(stop_pulse)
    );

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write monitor: pops the scoreboard
    always @(negedge clk) begin
        if (!rst && stop_pulse) stop_cnt++;
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write strobe", {reg_addr, reg_wdata}, 16'h0000);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
            end
            if (reg_addr < 8'd17) mem[reg_addr[4:0]] = reg_wdata;
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b1; wait_q(Q);
        exp_stops++;
    endtask

    // glitch: 1 = SCL spike in low phase of bit 4, 2 = SDA low spike in high phase of bit 4
    task automatic send_byte(input logic [7:0] b, input int glitch, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            if (glitch == 1 && i == 4) begin
                wait_q(Q/2); m_scl = 1'b1; wait_q(8); m_scl = 1'b0; wait_q(Q/2 - 8);
            end else wait_q(Q);
            m_scl = 1'b1;
            if (glitch == 2 && i == 4) begin
                wait_q(Q/2); m_sda = 1'b0; wait_q(8); m_sda = 1'b1; wait_q(Q/2 - 8);
            end else wait_q(Q);
            m_scl = 1'b0; wait_q(Q);
        end
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q/2);
        acked = ~sda_line;
        wait_q(Q/2);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        m_sda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wait_q(Q);
            m_scl = 1'b1; wait_q(Q/2);
            b = {b[6:0], sda_line};
            wait_q(Q/2);
            m_scl = 1'b0;
        end
        m_sda = ~ack; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] id_byte(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int glitch);
        logic ak;
        exp_q.push_back({a, d});
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), (glitch == 1) ? 1 : 0, ak);
        check(ak, "R1 write id ack", 16'(ak), 16'h1);
        send_byte(a, 0, ak);
        check(ak, "R3 addr ack", 16'(ak), 16'h1);
        send_byte(d, (glitch == 2) ? 2 : 0, ak);
        check(ak, "R3 data ack", 16'(ak), 16'h1);
        bus_stop();
    endtask

    // read n bytes from a; stop_after selects whether a STOP ends it
    task automatic do_read(input logic [7:0] a, input int n, input string req, input bit stop_after);
        logic ak;
        logic [7:0] got, p;
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), 0, ak);
        check(ak, "R1 id ack before read", 16'(ak), 16'h1);
        send_byte(a, 0, ak);
        check(ak, "R5 read addr ack", 16'(ak), 16'h1);
        bus_start();
        send_byte(id_byte(STRAP, 1'b1), 0, ak);
        check(ak, "R1 read id ack", 16'(ak), 16'h1);
        p = a;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, got);
            check(got == mem[p[4:0]], req, {8'h00, got}, {8'h00, mem[p[4:0]]});
            p = (p == 8'h0F) ? 8'h00 : p + 8'h01;
        end
        if (stop_after) bus_stop();
    endtask

    initial begin
        logic ak;
        for (int i = 0; i < 17; i++) mem[i] = 8'(8'h11 + 3 * i);
        repeat (10) @(negedge clk);
        check(!sda_drive_low, "R12 sda released in reset", 16'(sda_drive_low), 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!sda_drive_low, "R12 sda released after reset", 16'(sda_drive_low), 16'h0);
        check(!reg_we && !stop_pulse, "R12 no strobes after reset", {15'h0, reg_we}, 16'h0);
        wait_q(Q);

        // plain write
        do_write(8'h03, 8'hA5, 0);
        wait_q(Q);
        check(stop_cnt == exp_stops, "R8 stop pulse count", 16'(stop_cnt), 16'(exp_stops));
        check(exp_q.size() == 0, "R3 write delivered", 16'(exp_q.size()), 16'h0);

        // write followed by a surplus byte
        exp_q.push_back({8'h05, 8'h3C});
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), 0, ak);
        send_byte(8'h05, 0, ak);
        send_byte(8'h3C, 0, ak);
        check(ak, "R3 data ack", 16'(ak), 16'h1);
        send_byte(8'h77, 0, ak);
        check(!ak, "R4 surplus byte not acked", 16'(ak), 16'h0);
        bus_stop();
        wait_q(Q);
        check(exp_q.size() == 0 && mem[5] == 8'h3C, "R4 only first data byte written", {8'h00, mem[5]}, 16'h003C);

        // sequential read
        do_read(8'h03, 3, "R5 sequential read byte", 1'b1);

        // wrapping read, then a byte after NACK without START
        do_read(8'h0E, 4, "R6 wrapped read byte", 1'b0);
        send_byte(id_byte(STRAP, 1'b0), 0, ak);
        check(!ak, "R7 silent after master NACK", 16'(ak), 16'h0);
        check(!sda_drive_low, "R7 sda released after NACK", 16'(sda_drive_low), 16'h0);
        bus_stop();

        // wrong strap bits
        bus_start();
        send_byte(id_byte(3'b010, 1'b0), 0, ak);
        check(!ak, "R2 mismatched id not acked", 16'(ak), 16'h0);
        send_byte(8'h00, 0, ak);
        check(!ak, "R2 following byte not acked", 16'(ak), 16'h0);
        bus_stop();
        // wrong prefix
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, 0, ak);
        check(!ak, "R2 wrong prefix not acked", 16'(ak), 16'h0);
        bus_stop();

        // START while power-up busy
        pwr_busy = 1'b1;
        bus_start();
        send_byte(id_byte(STRAP, 1'b0), 0, ak);
        check(!ak, "R9 start ignored while busy", 16'(ak), 16'h0);
        bus_stop();
        pwr_busy = 1'b0;
        wait_q(Q);
        do_write(8'h07, 8'h5A, 0);

        // spikes on both lines
        do_write(8'h08, 8'hF0, 1);
        do_write(8'h09, 8'hF0, 2);
        wait_q(Q);
        check(mem[8] == 8'hF0 && mem[9] == 8'hF0, "R10 spikes ignored", {mem[8], mem[9]}, 16'hF0F0);
        do_read(8'h08, 2, "R10 read back after spikes", 1'b1);

        wait_q(Q);
        check(stop_cnt == exp_stops, "R8 total stop pulses", 16'(stop_cnt), 16'(exp_stops));
        check(exp_q.size() == 0, "R3 scoreboard drained", 16'(exp_q.size()), 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule